// File: doc/BRIEF.md
# DMA Channel Transfer Sequencer

One DMA channel with a 16-bit control word and three working registers: a transfer count and two addresses, one for the source and one for the destination. Software loads these through a small write port. Setting the run bit arms the channel. The channel then asks a simple bus handshake for transfers. It asks either all the time (free-running mode) or only while its chosen request line is high (source-paced or destination-paced mode). The request line is an external pin or an internal line, picked by a control bit.

A transfer completes in any cycle where `bus_req` and `bus_ack` are both high. Each completed transfer does three things:
- it lowers the count by one;
- it moves each address up, down or leaves it in place;
- it steps by one or by two.

When termination is in force, the channel clears its run bit at the transfer that takes the count to zero. It can also raise a level interrupt at that point. The priority bit goes straight to an output for an external arbiter. An illegal control setting raises an error flag and blocks all transfers.

The register contents drive the outputs directly, so software and the bench can read the state back.

Top module: `dma_chan_seq`

## Requirements
- R1: After reset, the control word, the count and both addresses are zero. `bus_req` and `irq` are low.
- R2: Control word layout:
  - bit 0: run.
  - bit 1: change-enable. It is write-only and reads as 0.
  - bit 2: word size. 1 means step by 2.
  - bit 3: terminal-count enable.
  - bit 4: interrupt enable.
  - bits 6:5: pacing mode. 00 free-running, 01 source-paced, 10 destination-paced, 11 illegal.
  - bit 7: priority.
  - bit 8: internal request select.
  - bits 9 and 10: source increment and source decrement.
  - bits 11 and 12: destination increment and destination decrement.
  - Bits 15:13 and bit 1 always read 0.
- R3: A control write changes the run bit only when bit 1 of the same write is 1. Otherwise the run bit keeps its value and the other fields still update.
- R4: `cfg_err` is 1 when the mode is 11, or when internal select is set with a mode other than 01. While `cfg_err` is 1, `bus_req` stays low.
- R5: With internal select set, only `int_req` paces requests and `ext_req` is ignored. With it clear, only `ext_req` paces requests.
- R6: In free-running mode, an armed channel holds `bus_req` high whatever the request lines do.
- R7: In the paced modes, `bus_req` is high only while the chosen request line is high. A transfer completes only in a cycle where both `bus_req` and `bus_ack` are high.
- R8: Each completed transfer lowers the count by one, modulo 2^16. Without a transfer the count holds.
- R9: On each transfer, each address moves according to its own increment and decrement bits:
  - increment only: it adds the step;
  - decrement only: it subtracts the step;
  - neither or both: it holds.
  - The step is 2 when the word-size bit is set and 1 otherwise.
- R10: Termination is in force when the terminal-count enable bit is set or the mode is free-running. When it is in force, the transfer that takes the count from 1 to 0 clears the run bit. In a paced mode with the enable bit clear, the count wraps and transfers go on.
- R11: `irq` goes high at a terminal-count stop only when both the interrupt enable and terminal-count enable bits are set. It stays high until the next control write.
- R12: `prio_hi` equals control bit 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select: 0 control, 1 count, 2 source address, 3 destination address |
| cfg_wdata | input | 16 | Write data |
| ext_req | input | 1 | External request pin |
| int_req | input | 1 | Internal request line |
| bus_ack | input | 1 | Bus handshake acknowledge |
| bus_req | output | 1 | Transfer request to the bus |
| bus_src_addr | output | AW | Current source address |
| bus_dst_addr | output | AW | Current destination address |
| bus_wide | output | 1 | Word-size transfer |
| prio_hi | output | 1 | Channel priority for an external arbiter |
| irq | output | 1 | Terminal-count interrupt request |
| cfg_err | output | 1 | Illegal control setting |
| ctrl_q | output | 16 | Control word read-back |
| count_q | output | CW | Transfer count read-back |

## Verification
The checks on count stepping and on the terminal-count stop assume one thing about the inputs: no count write or control write lands in a cycle where a transfer completes. The assertions are gated off for those cycles, because in that case the write takes priority by design. The bench keeps to this rule. It loads the count and the addresses only while `bus_ack` is low or the channel is disarmed. It stops a channel that keeps running only after first dropping `bus_ack`. The bench changes the request and acknowledge lines only on falling clock edges, so each rising edge sees settled handshake values.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;
  localparam int unsigned B_RUN     = 0;
  localparam int unsigned B_CHG     = 1;
  localparam int unsigned B_WIDE    = 2;
  localparam int unsigned B_TCEN    = 3;
  localparam int unsigned B_IEN     = 4;
  localparam int unsigned B_SYNC_LO = 5;
  localparam int unsigned B_PRIO    = 7;
  localparam int unsigned B_ISEL    = 8;
  localparam int unsigned B_SINC    = 9;
  localparam int unsigned B_SDEC    = 10;
  localparam int unsigned B_DINC    = 11;
  localparam int unsigned B_DDEC    = 12;
  localparam logic [15:0] CTRL_KEEP = 16'h1FFD;

  typedef enum logic [1:0] {
    PACE_FREE = 2'b00,
    PACE_SRC  = 2'b01,
    PACE_DST  = 2'b10,
    PACE_BAD  = 2'b11
  } pace_e;

  function automatic logic pace_illegal(pace_e p, logic isel);
    return (p == PACE_BAD) || (isel && (p != PACE_SRC));
  endfunction

  function automatic logic tc_in_force(pace_e p, logic tc_en);
    return tc_en || (p == PACE_FREE);
  endfunction
endpackage

// File: rtl/dma_ctrl_reg.sv
module dma_ctrl_reg
  import dma_chan_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [15:0] wdata,
  input  logic        stop_hit,
  output logic [15:0] ctrl,
  output logic        bad_cfg
);
  logic [15:0] nxt;

  always_comb begin
    nxt        = wdata & CTRL_KEEP;
    nxt[B_RUN] = wdata[B_CHG] ? wdata[B_RUN] : ctrl[B_RUN];
  end

  always_ff @(posedge clk) begin
    if (!rst_n)        ctrl <= '0;
    else if (wr_en)    ctrl <= nxt;
    else if (stop_hit) ctrl[B_RUN] <= 1'b0;
  end

  assign bad_cfg = pace_illegal(pace_e'(ctrl[B_SYNC_LO +: 2]), ctrl[B_ISEL]);
endmodule

// File: rtl/dma_addr_step.sv
module dma_addr_step #(
  parameter int unsigned AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] load_val,
  input  logic          adv,
  input  logic          inc,
  input  logic          dec,
  input  logic          wide,
  output logic [AW-1:0] addr
);
  function automatic logic [AW-1:0] next_addr(logic [AW-1:0] a, logic up,
                                               logic dn, logic w);
    logic [AW-1:0] sz;
    sz = w ? AW'(2) : AW'(1);
    case ({up, dn})
      2'b10:   return a + sz;
      2'b01:   return a - sz;
      default: return a;
    endcase
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n)   addr <= '0;
    else if (load) addr <= load_val;
    else if (adv)  addr <= next_addr(addr, inc, dec, wide);
  end
endmodule

// File: rtl/dma_chan_seq.sv
module dma_chan_seq
  import dma_chan_pkg::*;
#(
  parameter int unsigned AW = 16,
  parameter int unsigned CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [1:0]    cfg_sel,
  input  logic [15:0]   cfg_wdata,
  input  logic          ext_req,
  input  logic          int_req,
  input  logic          bus_ack,
  output logic          bus_req,
  output logic [AW-1:0] bus_src_addr,
  output logic [AW-1:0] bus_dst_addr,
  output logic          bus_wide,
  output logic          prio_hi,
  output logic          irq,
  output logic          cfg_err,
  output logic [15:0]   ctrl_q,
  output logic [CW-1:0] count_q
);
  localparam logic [CW-1:0] CNT_ONE = CW'(1);

  pace_e pace;
  logic  armed, qual_req, xfer_done, tc_hit, ctrl_wr;
  logic  [1:0] step_inc, step_dec, addr_ld;
  logic  [AW-1:0] addr_q [2];

  assign ctrl_wr = cfg_we && (cfg_sel == 2'd0);

  dma_ctrl_reg u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(ctrl_wr), .wdata(cfg_wdata),
    .stop_hit(tc_hit), .ctrl(ctrl_q), .bad_cfg(cfg_err)
  );

  assign pace      = pace_e'(ctrl_q[B_SYNC_LO +: 2]);
  assign armed     = ctrl_q[B_RUN] && !cfg_err;
  assign qual_req  = ctrl_q[B_ISEL] ? int_req : ext_req;
  assign bus_req   = armed && ((pace == PACE_FREE) || qual_req);
  assign xfer_done = bus_req && bus_ack;
  assign tc_hit    = xfer_done && (count_q == CNT_ONE) &&
                     tc_in_force(pace, ctrl_q[B_TCEN]);

  always_ff @(posedge clk) begin
    if (!rst_n) count_q <= '0;
    else if (cfg_we && (cfg_sel == 2'd1)) count_q <= CW'(cfg_wdata);
    else if (xfer_done) count_q <= count_q - CNT_ONE;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       irq <= 1'b0;
    else if (ctrl_wr) irq <= 1'b0;
    else if (tc_hit && ctrl_q[B_TCEN] && ctrl_q[B_IEN]) irq <= 1'b1;
  end

  assign step_inc = {ctrl_q[B_DINC], ctrl_q[B_SINC]};
  assign step_dec = {ctrl_q[B_DDEC], ctrl_q[B_SDEC]};
  assign addr_ld  = {cfg_we && (cfg_sel == 2'd3), cfg_we && (cfg_sel == 2'd2)};

  for (genvar side = 0; side < 2; side++) begin : g_side
    dma_addr_step #(.AW(AW)) u_addr (
      .clk(clk), .rst_n(rst_n), .load(addr_ld[side]),
      .load_val(AW'(cfg_wdata)), .adv(xfer_done),
      .inc(step_inc[side]), .dec(step_dec[side]), .wide(ctrl_q[B_WIDE]),
      .addr(addr_q[side])
    );
  end

  assign bus_src_addr = addr_q[0];
  assign bus_dst_addr = addr_q[1];
  assign bus_wide     = ctrl_q[B_WIDE];
  assign prio_hi      = ctrl_q[B_PRIO];
endmodule

// File: rtl/dma_chan_sva.sv
module dma_chan_sva
  import dma_chan_pkg::*;
#(
  parameter int unsigned CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cfg_we,
  input logic [1:0]    cfg_sel,
  input logic          ext_req,
  input logic          int_req,
  input logic          bus_ack,
  input logic          bus_req,
  input logic          irq,
  input logic          cfg_err,
  input logic [15:0]   ctrl_q,
  input logic [CW-1:0] count_q
);
  logic       done, cnt_wr;
  logic [1:0] mode;
  assign done   = bus_req && bus_ack;
  assign cnt_wr = cfg_we && (cfg_sel == 2'd1);
  assign mode   = ctrl_q[B_SYNC_LO +: 2];

  AST_ERR_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |-> !bus_req); // R4
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_q[B_RUN] |-> !bus_req); // R6
  AST_INT_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q[B_ISEL] && !int_req) |-> !bus_req); // R5
  AST_PACED_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode != 2'b00) && !ctrl_q[B_ISEL] && !ext_req) |-> !bus_req); // R7
  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !cnt_wr) |=> (count_q == $past(count_q) - CW'(1))); // R8
  AST_COUNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!done && !cnt_wr) |=> $stable(count_q)); // R8
  AST_TC_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !cfg_we && (count_q == CW'(1)) && (ctrl_q[B_TCEN] || mode == 2'b00))
    |=> !ctrl_q[B_RUN]); // R10
  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> ($past(ctrl_q[B_TCEN]) && $past(ctrl_q[B_IEN]))); // R11
  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q[15:13] == 3'b000) && !ctrl_q[B_CHG]); // R2
endmodule

bind dma_chan_seq dma_chan_sva #(.CW(CW)) u_sva (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
  .ext_req(ext_req), .int_req(int_req), .bus_ack(bus_ack), .bus_req(bus_req),
  .irq(irq), .cfg_err(cfg_err), .ctrl_q(ctrl_q), .count_q(count_q)
);

// File: tb/dma_chan_seq_test.sv
`timescale 1ns/1ps
module dma_chan_seq_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_sel = 2'd0;
  logic [15:0] cfg_wdata = 16'd0;
  logic        ext_req = 1'b0, int_req = 1'b0, bus_ack = 1'b0;
  logic        bus_req, bus_wide, prio_hi, irq, cfg_err;
  logic [15:0] bus_src_addr, bus_dst_addr, ctrl_q, count_q;
  int checks = 0, errors = 0, xfers = 0;

  dma_chan_seq uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .ext_req(ext_req), .int_req(int_req),
    .bus_ack(bus_ack), .bus_req(bus_req), .bus_src_addr(bus_src_addr),
    .bus_dst_addr(bus_dst_addr), .bus_wide(bus_wide), .prio_hi(prio_hi),
    .irq(irq), .cfg_err(cfg_err), .ctrl_q(ctrl_q), .count_q(count_q)
  );

  always #5 clk = ~clk;
  always @(posedge clk) if (bus_req && bus_ack) xfers++;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] s, input logic [15:0] d);
    @(negedge clk); cfg_we = 1'b1; cfg_sel = s; cfg_wdata = d;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  function automatic logic [15:0] mk(logic run, logic chg, logic wide, logic tc,
      logic ie, logic [1:0] md, logic pr, logic isel, logic si, logic sd,
      logic di, logic dd);
    return {3'b000, dd, di, sd, si, isel, pr, md, ie, tc, wide, chg, run};
  endfunction

  function automatic logic [15:0] exp_addr(logic [15:0] b, int n, logic up,
                                           logic dn, logic wide);
    int sz = wide ? 2 : 1;
    if (up && !dn) return b + 16'(n * sz);
    if (dn && !up) return b - 16'(n * sz);
    return b;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 ctrl", ctrl_q, 0); check("R1 count", count_q, 0);
    check("R1 src", bus_src_addr, 0); check("R1 dst", bus_dst_addr, 0);
    check("R1 req", bus_req, 0); check("R1 irq", irq, 0);

    wr(0, 16'hFFFF);
    check("R2 readback", ctrl_q, 16'h1FFD);
    check("R4 bad mode err", cfg_err, 1);
    ext_req = 1; int_req = 1; #1;
    check("R4 bad mode no req", bus_req, 0);
    wr(0, 16'h0002);
    check("R3 cleared", ctrl_q, 0);
    wr(0, 16'h0001);
    check("R3 run without chg", ctrl_q[0], 0);
    wr(0, 16'h0080);
    check("R12 prio set", prio_hi, 1);
    wr(0, 16'h0000);
    check("R12 prio clear", prio_hi, 0);

    wr(0, mk(1,1,0,0,0,2'b10,0,1,0,0,0,0));
    check("R4 isel with dst mode", cfg_err, 1); #1;
    check("R4 isel dst no req", bus_req, 0);
    wr(0, mk(1,1,0,0,0,2'b01,0,1,0,0,0,0));
    check("R4 isel src legal", cfg_err, 0);
    ext_req = 1; int_req = 0; #1;
    check("R5 ext ignored", bus_req, 0);
    ext_req = 0; int_req = 1; #1;
    check("R5 int drives", bus_req, 1);
    wr(0, mk(1,1,0,0,0,2'b01,0,0,0,0,0,0));
    ext_req = 0; int_req = 1; #1;
    check("R5 int ignored", bus_req, 0);
    ext_req = 1; int_req = 0; #1;
    check("R5 ext drives", bus_req, 1);
    wr(0, mk(1,1,0,0,0,2'b00,0,0,0,0,0,0));
    ext_req = 0; int_req = 0;
    repeat (3) @(negedge clk);
    check("R6 free-running request", bus_req, 1);
    wr(0, 16'h0002);

    // R7: paced with gaps in request and acknowledge
    wr(1, 16'd10); wr(2, 16'h1000);
    wr(0, mk(1,1,0,1,0,2'b01,0,0,1,0,0,0));
    bus_ack = 1;
    begin
      logic [7:0] pat = 8'b1011_0010;
      int base = xfers;
      for (int i = 0; i < 8; i++) begin
        ext_req = pat[i];
        @(negedge clk);
      end
      ext_req = 1; bus_ack = 0;
      repeat (3) @(negedge clk);
      check("R7 paced transfers", xfers - base, 4);
    end
    check("R8 count after paced", count_q, 16'd6);
    check("R9 src after paced", bus_src_addr, 16'h1004);
    wr(0, 16'h0002);

    // sweep: mode x tc x ie x width x address direction
    for (int md = 0; md < 3; md++)
      for (int tc = 0; tc < 2; tc++)
        for (int ie = 0; ie < 2; ie++)
          for (int wd = 0; wd < 2; wd++)
            for (int am = 0; am < 4; am++) begin
              logic si, sd, di, dd, eff;
              int base, n;
              si = am[0]; sd = am[1]; di = am[1]; dd = am[0];
              eff = (tc != 0) || (md == 0);
              bus_ack = 0; ext_req = 1; int_req = 0;
              wr(1, 16'd3); wr(2, 16'h1000); wr(3, 16'h2000);
              @(negedge clk); bus_ack = 1; base = xfers;
              wr(0, mk(1,1,wd[0],tc[0],ie[0],md[1:0],0,0,si,sd,di,dd));
              if (eff) begin
                repeat (8) @(negedge clk);
                n = 3;
                check("R10 stopped", ctrl_q[0], 0);
                check("R10 count zero", count_q, 0);
                check("R11 irq gate", irq, (ie != 0) && (tc != 0));
              end else begin
                repeat (4) @(negedge clk);
                bus_ack = 0;
                n = 4;
                check("R10 keeps running", ctrl_q[0], 1);
                check("R10 count wraps", count_q, 16'hFFFF);
                check("R11 no irq", irq, 0);
              end
              check("R8 transfer total", xfers - base, n);
              check("R9 src step", bus_src_addr, exp_addr(16'h1000, n, si, sd, wd[0]));
              check("R9 dst step", bus_dst_addr, exp_addr(16'h2000, n, di, dd, wd[0]));
              bus_ack = 0;
              wr(0, 16'h0002);
              check("R11 irq cleared by write", irq, 0);
            end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule